// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit

This unit adds or subtracts two 32-bit operands split into independent lanes: four 8-bit lanes or two 16-bit lanes. No opcode bit gives the lane width or the signedness. Both come from the band of register numbers that the destination and both sources share. A 2-bit mode field, together with a halving select, then picks one of three behaviours: wrap-around, clamp to range (saturate), or full-precision result divided by two (halving).

Operations enter through a valid/ready port and leave through a valid/ready port, with one register stage between them. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented from the next cycle. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle, so back-pressure on `out_ready` stalls the input. While `out_valid` is high and `out_ready` is low, the presented result is held unchanged. With `out_ready` tied high, `out_valid` lasts exactly one cycle for each accepted operation.

Top module: `simd_addsub_unit`

## Requirements
- R1: If all three register numbers lie in 2..15, the unit uses four 8-bit lanes, with lane i in result bits [8i+7:8i]. If all three lie in 16..29, it uses two 16-bit lanes, with lane i in bits [16i+15:16i].
- R2: With `mode`=00 and `op_half`=0, each lane returns (a+b) or (a-b) modulo 2^W. Its flag bit is the unsigned carry out of an add or the borrow of a subtract.
- R3: With `mode`=01 and `op_half`=0, and all registers in 2..7 (8-bit) or all in 16..23 (16-bit), lanes are signed. A result beyond range is clamped to the most positive or most negative lane value, and the lane flag is set.
- R4: With `mode`=01 and `op_half`=0, and all registers in 8..15 (8-bit) or all in 24..29 (16-bit), lanes are unsigned. Underflow clamps to zero, overflow clamps to all ones, and the lane flag is set.
- R5: With `op_half`=1 and `mode`=00, each lane returns floor((a±b)/2), computed with one extra bit so it never overflows. Signedness follows the same register bands as R3/R4. All flags are 0.
- R6: The operation is illegal if any of these holds: the register numbers do not share one width band; any register number is 0, 1, 30 or 31; `mode` is 10 or 11; `op_half`=1 with `mode`=01; or a saturating or halving operation mixes its signed and unsigned sub-bands. An illegal operation gives `illegal`=1, `result`=0 and `lane_flags`=0.
- R7: `lane_flags` bit i belongs to lane i. In 16-bit mode, bits 3:2 are 0.
- R8: `in_ready` = !`out_valid` | `out_ready`. An accepted operation raises `out_valid` on the next cycle. `out_valid` falls after a handshake on the output that has no new input accepted in the same cycle.
- R9: While `out_valid`=1 and `out_ready`=0, `result`, `lane_flags` and `illegal` stay stable.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| rd | input | 5 | Destination register number |
| rs1 | input | 5 | First source register number |
| rs2 | input | 5 | Second source register number |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| op_half | input | 1 | 1 = halving operation |
| mode | input | 2 | 00 wrap/halving, 01 saturate, others illegal |
| opa | input | 32 | First packed operand |
| opb | input | 32 | Second packed operand |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer accepts result |
| result | output | 32 | Packed lane result |
| lane_flags | output | 4 | Per-lane carry/borrow or clamp flags |
| illegal | output | 1 | Operation was rejected |

## Verification
The hardest situation to reach is a held result under back-pressure while the next operation waits at the input. It needs `out_ready` low in the cycle after an acceptance, with `in_valid` still high. The stimulus withholds `out_ready` at random in about one cycle of four and keeps offering operations back to back, so stalls land on every kind of operation. The clamp boundaries are hard to hit with random operands, so directed cases place lanes exactly at the signed and unsigned limits. Register triples are drawn per sub-band so that the signed, unsigned and mixed-band decodes all occur often.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int DATA_W   = 32;
  localparam int REG_W    = 5;
  localparam int NARROW_W = 8;
  localparam int WIDE_W   = 16;
  localparam int FLAG_W   = DATA_W / NARROW_W;

  // register bands
  localparam int NB_LO    = 2;
  localparam int NB_SPLIT = 8;
  localparam int NB_HI    = 15;
  localparam int WB_LO    = 16;
  localparam int WB_SPLIT = 24;
  localparam int WB_HI    = 29;

  typedef enum logic [1:0] {
    ARITH_WRAP = 2'd0,
    ARITH_SAT  = 2'd1,
    ARITH_HALF = 2'd2
  } arith_e;

  typedef struct packed {
    logic   wide;
    logic   sgn;
    arith_e kind;
    logic   bad;
  } dec_t;
endpackage

// File: rtl/simd_decode.sv
module simd_decode
  import simd_pkg::*;
(
  input  logic [REG_W-1:0] rd,
  input  logic [REG_W-1:0] rs1,
  input  logic [REG_W-1:0] rs2,
  input  logic             op_half,
  input  logic [1:0]       mode,
  output dec_t             dec
);
  function automatic logic band(input logic [REG_W-1:0] r, input int lo, input int hi);
    return (int'(r) >= lo) && (int'(r) <= hi);
  endfunction

  function automatic logic all3(input int lo, input int hi,
                                input logic [REG_W-1:0] a,
                                input logic [REG_W-1:0] b,
                                input logic [REG_W-1:0] c);
    return band(a, lo, hi) && band(b, lo, hi) && band(c, lo, hi);
  endfunction

  logic n_all, w_all, sgn_all, uns_all;

  always_comb begin
    n_all   = all3(NB_LO, NB_HI, rd, rs1, rs2);
    w_all   = all3(WB_LO, WB_HI, rd, rs1, rs2);
    sgn_all = all3(NB_LO, NB_SPLIT-1, rd, rs1, rs2) || all3(WB_LO, WB_SPLIT-1, rd, rs1, rs2);
    uns_all = all3(NB_SPLIT, NB_HI, rd, rs1, rs2)   || all3(WB_SPLIT, WB_HI, rd, rs1, rs2);

    dec.wide = w_all;
    dec.sgn  = 1'b0;
    dec.kind = ARITH_WRAP;
    dec.bad  = 1'b0;
    unique case ({op_half, mode})
      3'b000: begin
        dec.kind = ARITH_WRAP;
        dec.bad  = !(n_all || w_all);
      end
      3'b001: begin
        dec.kind = ARITH_SAT;
        dec.sgn  = sgn_all;
        dec.bad  = !(sgn_all || uns_all);
      end
      3'b100: begin
        dec.kind = ARITH_HALF;
        dec.sgn  = sgn_all;
        dec.bad  = !(sgn_all || uns_all);
      end
      default: dec.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         sgn,
  input  arith_e       kind,
  output logic [W-1:0] r,
  output logic         flag
);
  localparam int EW = W + 2;
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [EW-1:0] ea, eb, s;

  always_comb begin
    ea = {{2{sgn & a[W-1]}}, a};
    eb = {{2{sgn & b[W-1]}}, b};
    s  = sub ? (ea - eb) : (ea + eb);
    r    = s[W-1:0];
    flag = 1'b0;
    unique case (kind)
      ARITH_WRAP: flag = s[W];
      ARITH_SAT: begin
        if (sgn) begin
          if (s[W] != s[W-1]) begin
            flag = 1'b1;
            r    = s[W+1] ? SMIN : SMAX;
          end
        end else if (s[W+1]) begin
          flag = 1'b1;
          r    = '0;
        end else if (s[W]) begin
          flag = 1'b1;
          r    = '1;
        end
      end
      ARITH_HALF: r = s[W:1];
      default: r = '0;
    endcase
  end
endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  dec_t              dec,
  output logic [DATA_W-1:0] res,
  output logic [FLAG_W-1:0] flags
);
  localparam int NN = DATA_W / NARROW_W;
  localparam int NW = DATA_W / WIDE_W;

  logic [DATA_W-1:0] n_res, w_res;
  logic [NN-1:0]     n_flg;
  logic [NW-1:0]     w_flg;

  for (genvar i = 0; i < NN; i++) begin : g_narrow
    simd_lane #(.W(NARROW_W)) u_lane (
      .a(a[i*NARROW_W +: NARROW_W]), .b(b[i*NARROW_W +: NARROW_W]),
      .sub(sub), .sgn(dec.sgn), .kind(dec.kind),
      .r(n_res[i*NARROW_W +: NARROW_W]), .flag(n_flg[i]));
  end

  for (genvar i = 0; i < NW; i++) begin : g_wide
    simd_lane #(.W(WIDE_W)) u_lane (
      .a(a[i*WIDE_W +: WIDE_W]), .b(b[i*WIDE_W +: WIDE_W]),
      .sub(sub), .sgn(dec.sgn), .kind(dec.kind),
      .r(w_res[i*WIDE_W +: WIDE_W]), .flag(w_flg[i]));
  end

  always_comb begin
    if (dec.bad) begin
      res   = '0;
      flags = '0;
    end else if (dec.wide) begin
      res   = w_res;
      flags = {{(FLAG_W-NW){1'b0}}, w_flg};
    end else begin
      res   = n_res;
      flags = n_flg;
    end
  end
endmodule

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit
  import simd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [REG_W-1:0]  rd,
  input  logic [REG_W-1:0]  rs1,
  input  logic [REG_W-1:0]  rs2,
  input  logic              op_sub,
  input  logic              op_half,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] lane_flags,
  output logic              illegal
);
  dec_t              dec;
  logic [DATA_W-1:0] dp_res;
  logic [FLAG_W-1:0] dp_flg;
  logic              take;

  simd_decode u_dec (
    .rd(rd), .rs1(rs1), .rs2(rs2), .op_half(op_half), .mode(mode), .dec(dec));

  simd_datapath u_dp (
    .a(opa), .b(opb), .sub(op_sub), .dec(dec), .res(dp_res), .flags(dp_flg));

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      lane_flags <= '0;
      illegal    <= 1'b0;
    end else begin
      if (take) begin
        out_valid  <= 1'b1;
        result     <= dp_res;
        lane_flags <= dp_flg;
        illegal    <= dec.bad;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk
  import simd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [REG_W-1:0]  rd,
  input logic [REG_W-1:0]  rs1,
  input logic [REG_W-1:0]  rs2,
  input logic              op_half,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] result,
  input logic [FLAG_W-1:0] lane_flags,
  input logic              illegal
);
  logic all_wide;
  assign all_wide = (int'(rd) >= WB_LO) && (int'(rd) <= WB_HI) &&
                    (int'(rs1) >= WB_LO) && (int'(rs1) <= WB_HI) &&
                    (int'(rs2) >= WB_LO) && (int'(rs2) <= WB_HI);

  // R8
  accept_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R8
  drain_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(lane_flags) && $stable(illegal));

  // R6
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && illegal |-> result == '0 && lane_flags == '0);

  // R7
  wide_upper_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && all_wide |=> lane_flags[FLAG_W-1:2] == '0);

  // R5
  half_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && op_half |=> lane_flags == '0);
endmodule

bind simd_addsub_unit simd_addsub_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .rd(rd), .rs1(rs1), .rs2(rs2), .op_half(op_half),
  .out_valid(out_valid), .out_ready(out_ready), .result(result),
  .lane_flags(lane_flags), .illegal(illegal));

// File: tb/simd_addsub_unit_test.sv
module simd_addsub_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [4:0]  rd = 0, rs1 = 0, rs2 = 0;
  logic        op_sub = 0, op_half = 0;
  logic [1:0]  mode = 0;
  logic [31:0] opa = 0, opb = 0, result;
  logic [3:0]  lane_flags;
  logic        illegal;

  int checks = 0, fails = 0;
  bit done = 0;
  int rdy_pct = 75;

  typedef struct { logic [31:0] res; logic [3:0] flg; logic bad; string tag; } exp_t;
  exp_t q[$];
  bit hold_prev = 0;
  logic [31:0] prev_res; logic [3:0] prev_flg; logic prev_bad;

  simd_addsub_unit uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit inr(int r, int lo, int hi);
    return r >= lo && r <= hi;
  endfunction

  function automatic exp_t model(int d, int a1, int a2, bit sub, bit half, int md,
                                 logic [31:0] a, logic [31:0] b);
    exp_t e; bit n8, w16, sg, us; int W, kind; longint x, y, s, lim;
    e.res = 0; e.flg = 0; e.bad = 0;
    n8  = inr(d,2,15) && inr(a1,2,15) && inr(a2,2,15);
    w16 = inr(d,16,29) && inr(a1,16,29) && inr(a2,16,29);
    sg  = (inr(d,2,7) && inr(a1,2,7) && inr(a2,2,7)) || (inr(d,16,23) && inr(a1,16,23) && inr(a2,16,23));
    us  = (inr(d,8,15) && inr(a1,8,15) && inr(a2,8,15)) || (inr(d,24,29) && inr(a1,24,29) && inr(a2,24,29));
    if (!half && md == 0) begin kind = 0; e.bad = !(n8 || w16); sg = 0; e.tag = "R2"; end
    else if (!half && md == 1) begin kind = 1; e.bad = !(sg || us); e.tag = sg ? "R3" : "R4"; end
    else if (half && md == 0) begin kind = 2; e.bad = !(sg || us); e.tag = "R5"; end
    else begin kind = 3; e.bad = 1; end
    if (e.bad) begin e.tag = "R6"; return e; end
    if (w16) e.tag = {e.tag, "/R1"};
    W = w16 ? 16 : 8;
    lim = longint'(1) << W;
    for (int i = 0; i < 32 / W; i++) begin
      x = longint'((a >> (i*W))) & (lim - 1);
      y = longint'((b >> (i*W))) & (lim - 1);
      if (sg && x >= lim/2) x -= lim;
      if (sg && y >= lim/2) y -= lim;
      s = sub ? x - y : x + y;
      if (kind == 0) begin
        e.flg[i] = sub ? (s < 0) : (s >= lim);
      end else if (kind == 1) begin
        if (sg) begin
          if (s > lim/2 - 1) begin s = lim/2 - 1; e.flg[i] = 1; end
          if (s < -lim/2)    begin s = -lim/2;    e.flg[i] = 1; end
        end else begin
          if (s < 0)        begin s = 0;       e.flg[i] = 1; end
          if (s > lim - 1)  begin s = lim - 1; e.flg[i] = 1; end
        end
      end else begin
        s = s >>> 1;
      end
      s = s & (lim - 1);
      e.res = e.res | (32'(s) << (i*W));
    end
    return e;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one observation per cycle, at negedge + 1
  task automatic observe();
    exp_t e;
    chk(out_valid == (q.size() > 0), "R8", "out_valid", 32'(out_valid), 32'(q.size() > 0));
    chk(in_ready == (!out_valid || out_ready), "R8", "in_ready", 32'(in_ready), 32'(!out_valid || out_ready));
    if (hold_prev)
      chk(out_valid && result == prev_res && lane_flags == prev_flg && illegal == prev_bad,
          "R9", "held output", result, prev_res);
    hold_prev = out_valid && !out_ready;
    prev_res = result; prev_flg = lane_flags; prev_bad = illegal;
    if (out_valid && out_ready && q.size() > 0) begin
      e = q.pop_front();
      chk(result == e.res, e.tag, "result", result, e.res);
      chk(lane_flags == e.flg, {"R7/", e.tag}, "lane_flags", 32'(lane_flags), 32'(e.flg));
      chk(illegal == e.bad, e.tag, "illegal", 32'(illegal), 32'(e.bad));
    end
    if (in_valid && in_ready)
      q.push_back(model(rd, rs1, rs2, op_sub, op_half, mode, opa, opb));
  endtask

  task automatic send(int d, int a1, int a2, bit sub, bit half, int md,
                      logic [31:0] a, logic [31:0] b);
    bit acc = 0;
    while (!acc) begin
      @(negedge clk);
      in_valid = 1; rd = 5'(d); rs1 = 5'(a1); rs2 = 5'(a2);
      op_sub = sub; op_half = half; mode = 2'(md); opa = a; opb = b;
      out_ready = ($urandom % 100) < rdy_pct;
      #1;
      acc = in_ready;
      observe();
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; out_ready = 1;
      #1; observe();
    end
  endtask

  function automatic int pick_reg(int band);
    case (band)
      0: return 2 + $urandom % 6;
      1: return 8 + $urandom % 8;
      2: return 16 + $urandom % 8;
      3: return 24 + $urandom % 6;
      default: return $urandom % 32;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(out_valid == 0, "R10", "out_valid in reset", 32'(out_valid), 0);
    chk(in_ready == 1, "R10", "in_ready in reset", 32'(in_ready), 1);
    rst_n = 1;
    idle(2);
    // R1: same data, two widths
    send(2, 3, 4, 0, 0, 0, 32'h00FF00FF, 32'h00010001);
    send(16, 17, 29, 0, 0, 0, 32'h00FF00FF, 32'h00010001);
    // R2: wrap with borrow in every lane
    send(5, 9, 14, 1, 0, 0, 32'h00000000, 32'h01010101);
    // R3: signed clamp at both ends
    send(2, 3, 7, 0, 0, 1, 32'h7F807F00, 32'h01FF0180);
    send(16, 20, 23, 1, 0, 1, 32'h80007FFF, 32'h0001FFFF);
    // R4: unsigned clamp to zero and to all ones
    send(8, 9, 15, 1, 0, 1, 32'h05000010, 32'h06010010);
    send(24, 25, 29, 0, 0, 1, 32'hFFFF0001, 32'h00020001);
    // R5: halving, signed and unsigned
    send(16, 18, 23, 1, 1, 0, 32'h80007FFF, 32'h7FFF8000);
    send(8, 12, 15, 0, 1, 0, 32'hFFFFFF01, 32'hFFFF0100);
    send(2, 4, 6, 0, 1, 0, 32'h80FF7F01, 32'h80FF7F00);
    // R6: each illegal cause
    send(2, 3, 16, 0, 0, 0, 32'h11111111, 32'h22222222);
    send(0, 3, 4, 0, 0, 0, 32'h11111111, 32'h22222222);
    send(30, 20, 21, 0, 0, 0, 32'h11111111, 32'h22222222);
    send(2, 3, 4, 0, 0, 2, 32'h11111111, 32'h22222222);
    send(2, 3, 4, 0, 1, 1, 32'h11111111, 32'h22222222);
    send(2, 3, 8, 0, 0, 1, 32'h11111111, 32'h22222222);
    send(16, 24, 25, 0, 1, 0, 32'h11111111, 32'h22222222);
    idle(3);
    // random mix under back-pressure (R8, R9)
    for (int n = 0; n < 3000; n++) begin
      int bd = $urandom % 4;
      bit mix = ($urandom % 8) == 0;
      int a1 = pick_reg(mix ? 4 : bd), a2 = pick_reg(mix ? $urandom % 4 : bd);
      send(pick_reg(bd), a1, a2, $urandom % 2, ($urandom % 3) == 0, ($urandom % 5 == 0) ? $urandom % 4 : $urandom % 2,
           $urandom, ($urandom % 4 == 0) ? 32'hFFFFFFFF - $urandom % 256 : $urandom);
    end
    idle(4);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule